// File: doc/BRIEF.md
# Calibrated Seconds Divider

This block turns a stream of oscillator-cycle enables (nominally 32,768 per second) into a single-cycle pulse once per second. It is built from three stages:

- a divide-by-`PRE_DIV` prescaler (128 by default);
- a seconds stage that counts prescaler pulses (256 by default);
- a scheduler that tracks the second within the minute and the minute within a 64-minute calibration cycle.

Calibration is periodic counter correction. A 5-bit magnitude N and a sign bit select how the first second of each minute is treated. In the first 2×N minutes of every 64-minute cycle, that second is changed:

- With the sign set to positive, two prescaler periods are injected, so the second ends 256 oscillator cycles early and the clock runs faster.
- With the sign set to negative, one prescaler period is blanked, so the second lasts 128 oscillator cycles longer and the clock runs slower.

All other seconds are left at their nominal length. Magnitude and sign are sampled only when a calibration cycle wraps, so software may rewrite them at any time.

A stop input freezes the minute and cycle position and clears the partial second. Counting resumes from zero when stop is released.

Top module: `xtal_cal_divider`

## Requirements
- R1: With no correction, consecutive ticks are separated by exactly PRE_DIV×POST_DIV accepted oscillator enables (32,768 by default), and each tick is high for one clock.
- R2: An adjusted second with the sign input at 1 (positive) is 2×PRE_DIV enables shorter than nominal (32,512 by default).
- R3: An adjusted second with the sign input at 0 (negative) is PRE_DIV enables longer than nominal (32,896 by default).
- R4: A minute is SECS_PER_MIN ticks, and only the first second of a minute (second index 0) can be adjusted.
- R5: A minute with index m in 0..CYC_MINS-1 has its first second adjusted exactly when m < 2×N, where N is the latched magnitude.
- R6: A latched magnitude of 0 leaves every second at the nominal length.
- R7: Magnitude and sign are captured only on the tick that ends the last second of the last minute of a cycle. After reset the latched magnitude is 0.
- R8: While stop is high there is no tick, the partial second is discarded, and the minute and cycle position is held. The first tick after release comes one full second of the held position later.
- R9: Clocks with the oscillator enable low do not advance the divider.
- R10: During reset and on the first clock after it, the tick is low, and all counts start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock enable per oscillator cycle |
| stop | input | 1 | Halts the divider and clears the partial second |
| cal_mag | input | MAG_W | Calibration magnitude N |
| cal_pos | input | 1 | Calibration sign: 1 speeds up, 0 slows down |
| tick_1hz | output | 1 | One-clock pulse at the end of each second |

## Verification
Two events can fall in the same cycle: the tick that closes a calibration cycle, and the capture of new calibration values. The bench provokes this by rewriting magnitude and sign in the middle of a cycle. It then judges the change by the lengths of the first seconds of the following cycle, while the rest of the current cycle must still follow the old setting. A second overlap is a stop raised on the clock right after a tick. There the bench checks that the partial count is dropped and that the following interval is a full second for the held minute position.

// File: rtl/xcd_pkg.sv
package xcd_pkg;

  // Prescaler pulses that make up one second, given the adjustment state.
  function automatic int unsigned sec_limit(int unsigned post, logic adj, logic pos);
    if (!adj)     return post;
    else if (pos) return post - 2;
    else          return post + 1;
  endfunction

  // A minute is eligible for correction when its index is below 2*mag.
  function automatic logic min_eligible(int unsigned min_idx, int unsigned mag);
    return (min_idx < (2 * mag));
  endfunction

endpackage

// File: rtl/xcd_prescaler.sv
module xcd_prescaler #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  output logic pre_tc
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] cnt;

  assign pre_tc = osc_en && !stop && (cnt == PW'(PRE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (stop)   cnt <= '0;
    else if (pre_tc) cnt <= '0;
    else if (osc_en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xcd_sec_counter.sv
module xcd_sec_counter
  import xcd_pkg::*;
#(
  parameter int POST_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_tc,
  input  logic stop,
  input  logic adj_now,
  input  logic adj_pos,
  output logic sec_done
);
  localparam int CW = $clog2(POST_DIV + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_w;

  // Terminal count for this second: nominal, shortened or lengthened.
  assign last_w   = CW'(sec_limit(POST_DIV, adj_now, adj_pos) - 1);
  assign sec_done = pre_tc && (cnt == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (stop)     cnt <= '0;
    else if (sec_done) cnt <= '0;
    else if (pre_tc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xcd_cal_sched.sv
module xcd_cal_sched
  import xcd_pkg::*;
#(
  parameter int SECS_PER_MIN = 60,
  parameter int CYC_MINS     = 64,
  parameter int MAG_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_done,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             adj_now,
  output logic             adj_pos,
  output logic             cyc_wrap,
  output logic [MAG_W-1:0] mag_l
);
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam int MW = (CYC_MINS > 1) ? $clog2(CYC_MINS) : 1;

  logic [SW-1:0] sec_idx;
  logic [MW-1:0] min_idx;
  logic          pos_l;
  logic          last_sec;
  logic          last_min;

  assign last_sec = (sec_idx == SW'(SECS_PER_MIN - 1));
  assign last_min = (min_idx == MW'(CYC_MINS - 1));
  assign cyc_wrap = sec_done && last_sec && last_min;
  assign adj_now  = (sec_idx == '0) && min_eligible(32'(min_idx), 32'(mag_l));
  assign adj_pos  = pos_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_idx <= '0;
      min_idx <= '0;
      mag_l   <= '0;
      pos_l   <= 1'b0;
    end else if (sec_done) begin
      sec_idx <= last_sec ? '0 : sec_idx + 1'b1;
      if (last_sec) min_idx <= last_min ? '0 : min_idx + 1'b1;
      if (cyc_wrap) begin
        mag_l <= cal_mag;
        pos_l <= cal_pos;
      end
    end
  end
endmodule

// File: rtl/xtal_cal_divider.sv
module xtal_cal_divider #(
  parameter int PRE_DIV      = 128,
  parameter int POST_DIV     = 256,
  parameter int SECS_PER_MIN = 60,
  parameter int CYC_MINS     = 64,
  parameter int MAG_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             tick_1hz
);
  logic             pre_tc;
  logic             sec_done;
  logic             adj_now;
  logic             adj_pos;
  logic             cyc_wrap;
  logic [MAG_W-1:0] mag_l;
  logic             tick_q;

  xcd_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .pre_tc(pre_tc)
  );

  xcd_sec_counter #(.POST_DIV(POST_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc), .stop(stop),
    .adj_now(adj_now), .adj_pos(adj_pos), .sec_done(sec_done)
  );

  xcd_cal_sched #(
    .SECS_PER_MIN(SECS_PER_MIN), .CYC_MINS(CYC_MINS), .MAG_W(MAG_W)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .sec_done(sec_done),
    .cal_mag(cal_mag), .cal_pos(cal_pos),
    .adj_now(adj_now), .adj_pos(adj_pos), .cyc_wrap(cyc_wrap), .mag_l(mag_l)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= sec_done;
  end

  assign tick_1hz = tick_q;
endmodule

// File: rtl/xcd_checker.sv
module xcd_checker #(
  parameter int PRE_DIV  = 128,
  parameter int POST_DIV = 256,
  parameter int MAG_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             stop,
  input logic             tick_1hz,
  input logic             sec_done,
  input logic             adj_now,
  input logic             adj_pos,
  input logic             cyc_wrap,
  input logic [MAG_W-1:0] mag_l
);
  localparam int unsigned NOM  = PRE_DIV * POST_DIV;
  localparam int unsigned FAST = NOM - 2 * PRE_DIV;
  localparam int unsigned SLOW = NOM + PRE_DIV;

  // Accepted oscillator enables since the last completed second.
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap <= 0;
    else if (stop)     gap <= 0;
    else if (sec_done) gap <= 0;
    else if (osc_en)   gap <= gap + 1;
  end

  p_len_nominal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done && !adj_now) |-> (gap + 1 == NOM));

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  p_len_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done && adj_now && adj_pos) |-> (gap + 1 == FAST));

  p_len_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done && adj_now && !adj_pos) |-> (gap + 1 == SLOW));

  p_zero_mag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_l == '0) |-> !adj_now);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wrap |=> $stable({mag_l, adj_pos}));

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !tick_1hz);

  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> !tick_1hz);
endmodule

bind xtal_cal_divider xcd_checker #(
  .PRE_DIV(PRE_DIV), .POST_DIV(POST_DIV), .MAG_W(MAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
  .tick_1hz(tick_1hz), .sec_done(sec_done), .adj_now(adj_now),
  .adj_pos(adj_pos), .cyc_wrap(cyc_wrap), .mag_l(mag_l)
);

// File: tb/xtal_cal_divider_test.sv
`timescale 1ns/1ps
module xtal_cal_divider_test;
  localparam int PRE  = 4;
  localparam int POST = 8;
  localparam int SPM  = 4;
  localparam int CYC  = 64;
  localparam int NOM  = PRE * POST;   // R1 nominal second
  localparam int FAST = NOM - 2 * PRE; // R2 shortened second
  localparam int SLOW = NOM + PRE;     // R3 lengthened second

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b1;
  logic       stop = 1'b0;
  logic [4:0] cal_mag = 5'd3;
  logic       cal_pos = 1'b1;
  logic       tick_1hz;
  logic       gap_mode = 1'b0;

  int   checks = 0;
  int   fails = 0;
  int   cnt = 0;
  bit   done = 0;
  bit   chg_pending = 0;
  bit   after_stop = 0;
  int   len_q[$];
  string tag_q[$];

  // bench reference position
  int bm_sec = 0, bm_min = 0, bm_mag = 0;
  bit bm_pos = 0;

  always #2.5 clk = ~clk;

  xtal_cal_divider #(
    .PRE_DIV(PRE), .POST_DIV(POST), .SECS_PER_MIN(SPM), .CYC_MINS(CYC), .MAG_W(5)
  ) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .cal_mag(cal_mag), .cal_pos(cal_pos), .tick_1hz(tick_1hz)
  );

  // R9: in gap mode the oscillator enable toggles every clock
  always @(posedge clk) begin
    #1 osc_en <= gap_mode ? ~osc_en : 1'b1;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Driver: pushes the expected length of each upcoming second.
  task automatic run_secs(int n);
    for (int i = 0; i < n; i++) begin
      bit    adj;
      int    len;
      string tag;
      adj = (bm_sec == 0) && (bm_min < 2 * bm_mag);
      if (adj) begin
        len = bm_pos ? FAST : SLOW;
        tag = bm_pos ? "R2 R5" : "R3 R5";
      end else begin
        len = NOM;
        if (bm_mag == 0)       tag = "R6 R1";
        else if (bm_sec != 0)  tag = "R4 R1";
        else                   tag = "R5 R1";
      end
      if (chg_pending) tag = {tag, " R7"};
      if (gap_mode)    tag = {tag, " R9"};
      if (after_stop) begin
        tag = {tag, " R8"};
        after_stop = 0;
      end
      len_q.push_back(len);
      tag_q.push_back(tag);
      if (bm_sec == SPM - 1 && bm_min == CYC - 1) begin
        bm_mag = cal_mag;
        bm_pos = cal_pos;
        chg_pending = 0;
      end
      if (bm_sec == SPM - 1) begin
        bm_sec = 0;
        bm_min = (bm_min == CYC - 1) ? 0 : bm_min + 1;
      end else begin
        bm_sec++;
      end
    end
    while (len_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops one expectation per tick and compares the measured length.
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (tick_1hz !== 1'b0) begin
        fails++;
        $display("FAIL R10 tick during reset: actual %0b expected 0", tick_1hz);
      end
      cnt = 0;
    end else if (stop) begin
      checks++;
      if (tick_1hz !== 1'b0) begin
        fails++;
        $display("FAIL R8 tick while stopped: actual %0b expected 0", tick_1hz);
      end
      cnt = 0;
    end else begin
      if (tick_1hz) begin
        checks++;
        if (len_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected tick: actual length %0d expected none", cnt);
        end else begin
          int    e;
          string t;
          e = len_q.pop_front();
          t = tag_q.pop_front();
          if (cnt != e) begin
            fails++;
            $display("FAIL %s second length: actual %0d expected %0d", t, cnt, e);
          end
        end
        cnt = 0;
      end
      if (osc_en) cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R10: reset holds the tick low; latched magnitude starts at 0
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b1;
    // cycle 0 runs uncorrected (R6, R10); magnitude 3 positive is captured at its end
    run_secs(CYC * SPM);
    // cycle 1: mag 3 positive; rewrite to 31 negative mid-cycle (R7)
    run_secs(100);
    cal_mag = 5'd31;
    cal_pos = 1'b0;
    chg_pending = 1;
    run_secs(CYC * SPM - 100);
    // cycle 2: mag 31 negative; stop right after a tick (R8)
    run_secs(70);
    @(posedge clk); #1 stop = 1'b1;
    repeat (40) @(posedge clk);
    #1 stop = 1'b0;
    after_stop = 1;
    run_secs(CYC * SPM - 70);
    // cycle 3: mag 31 negative with enable gaps (R9); then mag 2 positive
    gap_mode = 1'b1;
    cal_mag = 5'd2;
    cal_pos = 1'b1;
    chg_pending = 1;
    run_secs(CYC * SPM);
    gap_mode = 1'b0;
    // cycle 4: mag 2 positive, first minutes only
    run_secs(6 * SPM);
    done = 1;
    report();
    $finish;
  end
endmodule